// File: doc/BRIEF.md
# Interpolating One-Bit Delta-Sigma DAC Modulator

This block turns a stream of signed 30-bit samples into a one-bit pulse-density stream at the full clock rate, for a DAC that is followed by an analog low-pass filter. It fetches its own samples. Once per oversampling period it raises a fetch strobe and takes the word offered on its sample input. Between two fetches it moves linearly from one sample to the next, adding a fixed step on every clock. That running value drives a noise-shaping loop. The loop can be first order or second order, chosen at run time, and its one-bit decision leaves the block as a complementary pair.

The oversampling ratio is 32, 64, 128 or 256, selected by a two-bit input. A new ratio takes effect at the next fetch, so a ramp always spans exactly the period it was computed for. Before the loop, the input is limited to three quarters of full scale so that the second-order loop stays stable. One instance serves each of the I and Q paths.

Top module: `sd_dac_interp`

## Requirements
- R1: `sample_rd` is high for one cycle in every OSR cycles, where OSR = 32 << `osr_sel` (00→32, 01→64, 10→128, 11→256). A changed `osr_sel` sets the length of the period that begins at the next strobe.
- R2: While `rst_n` is low, `sample_rd` is 0, `dac_p` is 1 and `dac_n` is 0.
- R3: `sample_in` is captured only on the clock edge that ends a cycle in which `sample_rd` is high. Values offered in any other cycle have no effect on the output.
- R4: After each capture, the interpolated value starts at the previously captured sample. It then moves toward the new sample by (new − previous)/OSR per clock and reaches the new sample exactly after OSR clocks. The result is a one-period latency and a straight-line ramp.
- R5: With `order2` = 0 and a constant input x (two's complement; −2^29 maps to density 0 and +2^29 to density 1), the fraction of cycles with `dac_p` = 1 over a long window is (x + 2^29)/2^30 within a few counts.
- R6: With `order2` = 1 the same density relation holds, and the loop integrators stay bounded.
- R7: Inputs above +3·2^27 or below −3·2^27 are limited to those values before the loop, in both orders.
- R8: `dac_n` is always the complement of `dac_p`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock; output bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| osr_sel | input | 2 | Oversampling ratio select, OSR = 32 << osr_sel |
| order2 | input | 1 | 1 selects the second-order loop, 0 the first-order loop |
| sample_in | input | 30 | Signed input sample, taken in a strobe cycle |
| sample_rd | output | 1 | Fetch strobe, one cycle per OSR clocks |
| dac_p | output | 1 | One-bit output, true polarity |
| dac_n | output | 1 | One-bit output, inverted polarity |

## Verification
At each fetch edge, three things happen in the same cycle: the last step of the old ramp is added, the new sample and step are loaded, and the counter is reloaded with the ratio that the new step was divided by. A checker requires the interpolated value one cycle after every strobe to equal the sample captured one strobe earlier, bit for bit. The bench changes the ratio between table rows to make a reload and a step coincide with a ratio change. It also offers a deep negative value in every cycle except the strobe cycles, and judges the result by the pulse density, which must match only the strobed value. A step from zero measured over exactly one ramp period must show half the step's density, not the full step.

// File: rtl/sd_dac_pkg.sv
package sd_dac_pkg;

   localparam int OSR_SEL_W   = 2;
   localparam int OSR_LOG_MIN = 5;
   localparam int OSR_LOG_MAX = OSR_LOG_MIN + (1 << OSR_SEL_W) - 1;

   typedef enum logic {
      LOOP_FIRST  = 1'b0,
      LOOP_SECOND = 1'b1
   } loop_order_e;

   // log2 of the oversampling ratio for a select code
   function automatic int osr_log(input logic [OSR_SEL_W-1:0] sel);
      return OSR_LOG_MIN + int'(sel);
   endfunction

endpackage

// File: rtl/sd_rate_gen.sv
module sd_rate_gen
   import sd_dac_pkg::*;
#(
   parameter int CW = OSR_LOG_MAX
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [OSR_SEL_W-1:0] osr_sel,
   output logic                 fetch
);

   logic          armed_q;
   logic [CW-1:0] cnt_q;

   if (CW < OSR_LOG_MAX) begin : g_bad_cw
      $error("sd_rate_gen: counter too narrow for the largest ratio");
   end

   assign fetch = armed_q && (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         cnt_q   <= '0;
      end else begin
         armed_q <= 1'b1;
         if (fetch)
            cnt_q <= CW'((32'd1 << osr_log(osr_sel)) - 32'd1);
         else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
      end
   end

endmodule

// File: rtl/sd_ramp_interp.sv
module sd_ramp_interp
   import sd_dac_pkg::*;
#(
   parameter int DW   = 30,
   parameter int FRAC = OSR_LOG_MAX
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   load,
   input  logic [OSR_SEL_W-1:0]   osr_sel,
   input  logic signed [DW-1:0]   sample,
   output logic signed [DW+FRAC:0] ramp
);

   if (FRAC < OSR_LOG_MAX) begin : g_bad_frac
      $error("sd_ramp_interp: FRAC must cover the largest ratio exactly");
   end

   logic signed [DW-1:0]   prev_q;
   logic signed [DW+FRAC:0] step_q;
   logic signed [DW+FRAC:0] acc_q;
   logic signed [DW:0]      diff;
   logic signed [DW+FRAC:0] diff_ext;
   logic signed [DW+FRAC:0] step_next;

   // exact division: the fraction bits hold every bit shifted out
   always_comb begin
      diff      = {sample[DW-1], sample} - {prev_q[DW-1], prev_q};
      diff_ext  = {diff, {FRAC{1'b0}}};
      step_next = diff_ext >>> osr_log(osr_sel);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= '0;
         step_q <= '0;
         acc_q  <= '0;
      end else begin
         acc_q <= acc_q + step_q;
         if (load) begin
            prev_q <= sample;
            step_q <= step_next;
         end
      end
   end

   assign ramp = acc_q;

endmodule

// File: rtl/sd_nshape_loop.sv
module sd_nshape_loop #(
   parameter int DW         = 30,
   parameter int GUARD      = 6,
   parameter int LIM_SHIFT  = 2,
   parameter bit HAS_ORDER2 = 1'b1,
   parameter int IW         = DW + GUARD
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 order2,
   input  logic signed [DW:0]   u,
   output logic                 bit_out,
   output logic signed [IW-1:0] x2_mon
);

   localparam logic signed [IW-1:0] FS  = {{GUARD{1'b0}}, 1'b1, {(DW-1){1'b0}}};
   localparam logic signed [IW-1:0] LIM = FS - (FS >>> LIM_SHIFT);

   if (GUARD < 4) begin : g_bad_guard
      $error("sd_nshape_loop: GUARD too small for loop headroom");
   end
   if (LIM_SHIFT < 2) begin : g_bad_lim
      $error("sd_nshape_loop: input limit too close to full scale");
   end

   logic signed [IW-1:0] u_ext, u_lim, fb, x1_q, x1_n;
   logic                 y;

   always_comb begin
      u_ext = {{(GUARD-1){u[DW]}}, u};
      if (u_ext > LIM)
         u_lim = LIM;
      else if (u_ext < -LIM)
         u_lim = -LIM;
      else
         u_lim = u_ext;
      fb   = y ? FS : -FS;
      x1_n = x1_q + u_lim - fb;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         x1_q <= '0;
      else
         x1_q <= x1_n;
   end

   if (HAS_ORDER2) begin : g_order2
      logic signed [IW-1:0] x2_q, x2_n;
      assign x2_n = x2_q + x1_n - fb;
      assign y    = order2 ? ~x2_q[IW-1] : ~x1_q[IW-1];
      always_ff @(posedge clk) begin
         if (!rst_n || !order2)
            x2_q <= '0;
         else
            x2_q <= x2_n;
      end
      assign x2_mon = x2_q;
   end else begin : g_order1
      logic unused_sel;
      assign unused_sel = order2;
      assign y          = ~x1_q[IW-1];
      assign x2_mon     = '0;
   end

   assign bit_out = y;

endmodule

// File: rtl/sd_dac_interp.sv
module sd_dac_interp
   import sd_dac_pkg::*;
#(
   parameter int DW         = 30,
   parameter int FRAC       = OSR_LOG_MAX,
   parameter int GUARD      = 6,
   parameter int LIM_SHIFT  = 2,
   parameter bit HAS_ORDER2 = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0]           osr_sel,
   input  logic                 order2,
   input  logic signed [DW-1:0] sample_in,
   output logic                 sample_rd,
   output logic                 dac_p,
   output logic                 dac_n
);

   localparam int IW = DW + GUARD;

   if (DW < 8) begin : g_bad_dw
      $error("sd_dac_interp: sample width too small");
   end

   logic                   fetch_w;
   logic                   bit_w;
   logic signed [DW+FRAC:0] ramp_w;
   logic signed [IW-1:0]   x2_w;

   sd_rate_gen #(.CW(OSR_LOG_MAX)) u_rate (
      .clk     (clk),
      .rst_n   (rst_n),
      .osr_sel (osr_sel),
      .fetch   (fetch_w)
   );

   sd_ramp_interp #(.DW(DW), .FRAC(FRAC)) u_ramp (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (fetch_w),
      .osr_sel (osr_sel),
      .sample  (sample_in),
      .ramp    (ramp_w)
   );

   sd_nshape_loop #(
      .DW(DW), .GUARD(GUARD), .LIM_SHIFT(LIM_SHIFT), .HAS_ORDER2(HAS_ORDER2)
   ) u_loop (
      .clk     (clk),
      .rst_n   (rst_n),
      .order2  (order2 == LOOP_SECOND),
      .u       (ramp_w[DW+FRAC:FRAC]),
      .bit_out (bit_w),
      .x2_mon  (x2_w)
   );

   assign sample_rd = fetch_w;
   assign dac_p     = bit_w;
   assign dac_n     = ~bit_w;

endmodule

// File: rtl/sd_dac_interp_chk.sv
module sd_dac_interp_chk #(
   parameter int DW    = 30,
   parameter int FRAC  = 8,
   parameter int GUARD = 6
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [1:0]                osr_sel,
   input logic signed [DW-1:0]      sample_in,
   input logic                      sample_rd,
   input logic                      dac_p,
   input logic                      dac_n,
   input logic signed [DW+FRAC:0]   ramp,
   input logic signed [DW+GUARD-1:0] x2
);

   localparam int IW = DW + GUARD;
   localparam logic signed [IW-1:0] BOUND = {2'b01, {(IW-2){1'b0}}};

   logic [9:0]           gap_q, per_q;
   logic                 seen_q;
   logic signed [DW-1:0] cap_last_q, cap_prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap_q      <= '0;
         per_q      <= '0;
         seen_q     <= 1'b0;
         cap_last_q <= '0;
         cap_prev_q <= '0;
      end else if (sample_rd) begin
         gap_q      <= 10'd1;
         per_q      <= 10'(32 << osr_sel);
         seen_q     <= 1'b1;
         cap_last_q <= sample_in;
         cap_prev_q <= cap_last_q;
      end else begin
         gap_q <= gap_q + 1'b1;
      end
   end

   // R1: strobe spacing equals the ratio latched at the previous strobe
   p_rd_period_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_rd && seen_q) |-> (gap_q == per_q));
   p_rd_early_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!sample_rd && seen_q) |-> (gap_q < per_q));

   // R2: outputs idle as reset is released
   p_reset_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (dac_p && !dac_n && !sample_rd));

   // R4: the ramp lands exactly on the sample captured one strobe earlier
   p_ramp_land_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sample_rd |=> (ramp == $signed({cap_prev_q[DW-1], cap_prev_q, {FRAC{1'b0}}})));

   // R6: second integrator stays within its guard range
   p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (x2 < BOUND) && (x2 > -BOUND));

   // R8: complementary output pair
   p_complement_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dac_n == !dac_p);

endmodule

bind sd_dac_interp sd_dac_interp_chk #(.DW(DW), .FRAC(FRAC), .GUARD(GUARD)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .osr_sel   (osr_sel),
   .sample_in (sample_in),
   .sample_rd (sample_rd),
   .dac_p     (dac_p),
   .dac_n     (dac_n),
   .ramp      (ramp_w),
   .x2        (x2_w)
);

// File: tb/sd_dac_interp_test.sv
module sd_dac_interp_test;

   localparam int DW   = 30;
   localparam int NV   = 10;
   localparam int WIN  = 4096;
   localparam logic signed [DW-1:0] JUNK = {1'b1, {(DW-1){1'b0}}};

   // vector table: ratio select, loop order, constant input, expected ones in WIN
   localparam int T_SEL [NV] = '{0, 1, 2, 3, 0, 1, 2, 3, 1, 0};
   localparam int T_ORD [NV] = '{0, 0, 0, 0, 1, 1, 1, 1, 1, 0};
   localparam int T_VAL [NV] = '{0, 268435456, -134217728, 201326592, -335544320,
                                 0, 134217728, -201326592, 536870911, -536870912};
   localparam int T_EXP [NV] = '{2048, 3072, 1536, 2816, 768,
                                 2048, 2560, 1280, 3584, 512};

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic [1:0]           osr_sel = 2'd1;
   logic                 order2 = 1'b0;
   logic signed [DW-1:0] sample_in;
   logic                 sample_rd, dac_p, dac_n;

   int  cur_val = 0;
   bit  junk_en = 1'b0;
   int  checks = 0;
   int  fails  = 0;
   bit  done   = 1'b0;

   always #2 clk = ~clk;

   always_comb sample_in = (!junk_en || sample_rd) ? DW'(cur_val) : JUNK;

   sd_dac_interp uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .osr_sel   (osr_sel),
      .order2    (order2),
      .sample_in (sample_in),
      .sample_rd (sample_rd),
      .dac_p     (dac_p),
      .dac_n     (dac_n)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic wait_strobes(input int n);
      int seen = 0;
      while (seen < n) begin
         @(negedge clk);
         if (sample_rd) seen++;
      end
   endtask

   task automatic measure_gap(output int g);
      do @(negedge clk); while (!sample_rd);
      g = 0;
      do begin
         @(negedge clk);
         g++;
      end while (!sample_rd);
   endtask

   task automatic count_ones(input int w, output int ones, output int mism);
      ones = 0;
      mism = 0;
      for (int k = 0; k < w; k++) begin
         @(negedge clk);
         if (dac_p) ones++;
         if (dac_n == dac_p) mism++;
      end
   endtask

   function automatic int absdiff(input int a, input int b);
      return (a > b) ? a - b : b - a;
   endfunction

   initial begin
      int g, ones, mism, exp_r;
      string req;
      repeat (5) @(negedge clk);
      // R2: reset state
      chk(dac_p == 1'b1, "R2", "dac_p in reset", int'(dac_p), 1);
      chk(dac_n == 1'b0, "R2", "dac_n in reset", int'(dac_n), 0);
      chk(sample_rd == 1'b0, "R2", "sample_rd in reset", int'(sample_rd), 0);
      rst_n = 1'b1;

      // table walk: R1 period, R5/R6/R7 density, R8 complement
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         osr_sel = 2'(T_SEL[i]);
         order2  = T_ORD[i][0];
         cur_val = T_VAL[i];
         wait_strobes(3);
         measure_gap(g);
         chk(g == (32 << T_SEL[i]), "R1", "strobe period", g, 32 << T_SEL[i]);
         repeat (64) @(negedge clk);
         count_ones(WIN, ones, mism);
         req = (i >= 8) ? "R7" : (T_ORD[i] != 0 ? "R6" : "R5");
         chk(absdiff(ones, T_EXP[i]) <= 4, req, "pulse density", ones, T_EXP[i]);
         chk(mism == 0, "R8", "complement mismatches", mism, 0);
      end

      // R4: step from zero, density over exactly one ramp period is half the step
      @(negedge clk);
      osr_sel = 2'd3;
      order2  = 1'b0;
      cur_val = 0;
      wait_strobes(4);
      do @(negedge clk); while (!sample_rd);
      cur_val = 268435456;
      @(negedge clk);
      count_ones(256, ones, mism);
      exp_r = 160;
      chk(absdiff(ones, exp_r) <= 3, "R4", "ramp period density", ones, exp_r);

      // R3: values offered outside strobe cycles have no effect
      @(negedge clk);
      osr_sel = 2'd0;
      order2  = 1'b1;
      cur_val = 134217728;
      junk_en = 1'b1;
      wait_strobes(4);
      repeat (64) @(negedge clk);
      count_ones(WIN, ones, mism);
      chk(absdiff(ones, 2560) <= 4, "R3", "density with off-strobe junk", ones, 2560);
      junk_en = 1'b0;

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule